// File: doc/BRIEF.md
# Priority Arbiter with Fairness Lockout

This block decides which of up to sixteen requesters gets a single shared transfer resource. Each requester has a priority register that can be loaded while the block runs. The arbiter decides only when the resource is free. The winner keeps its grant until the transfer-done strobe arrives. One cycle after that strobe the arbiter decides again.

A global fairness switch sets the policy. With the switch off, the arbiter uses plain priority, so a strong requester can win every round. With the switch on, each requester that finishes a transfer is locked out. The lockout lasts until no unlocked requester is left waiting. When that happens, every lockout clears and a new round starts. In that same decision cycle the full request set competes again. A locked requester that drops its request is treated as idle and does not hold the round open.

Top module: `fair_prio_arbiter`

## Requirements
- R1: A synchronous active-high reset clears the grant, the busy flag and every lockout. It also loads each priority register with its own requester index, so with reset priorities the lowest requesting index wins.
- R2: The candidate with the numerically smallest 4-bit priority value wins. When two candidates have equal values, the lower requester index wins.
- R3: While a grant is held, exactly one grant bit is set, the encoded index equals that bit's position, and busy is high.
- R4: A held grant does not change until the transfer-done strobe, whatever happens to the request lines.
- R5: When the strobe is sampled during a grant, the next cycle shows grant all zeros and busy low. The new decision is visible one cycle after that.
- R6: With no candidate pending, the grant vector is zero and busy is low.
- R7: With fairness off, a requester that has just finished can win again immediately.
- R8: With fairness on, a finished requester is locked out while any unlocked requester is pending, so other waiting requesters are served in priority order.
- R9: When no unlocked requester is pending, all lockouts clear and the full request set competes in the same decision cycle.
- R10: A locked requester that has withdrawn its request does not keep another requester out of the next round.
- R11: A write strobe loads the priority data into the register selected by the write index, and that value is used from the next decision on.
- R12: A transfer-done strobe while the block is idle has no effect: no grant is dropped, and a grant issued in that cycle is held.
- R13: Turning fairness off clears all lockouts, even while a grant is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqVec | input | NUM_REQ | Request line per requester |
| fairEn | input | 1 | Fairness lockout enable |
| xferDone | input | 1 | Transfer-done strobe for the held grant |
| prioWrEn | input | 1 | Priority register write strobe |
| prioWrIdx | input | IDX_W | Requester whose priority is written |
| prioWrData | input | PRIO_W | Priority value written (lower is stronger) |
| grantVec | output | NUM_REQ | One-hot grant |
| grantIdx | output | IDX_W | Encoded index of the granted requester |
| busy | output | 1 | Resource is granted |

## Verification
The bench uses the default sixteen requesters with 4-bit priorities. With these widths the reset priorities 0 to 15 are all distinct, so the reset ordering is observable. Requester 15 can win at the top of the index range. Priority writes of zero can build ties between distant indices. Three-requester patterns let the bench follow a full fairness round, the round reset, and a lockout cleared in the middle of a grant.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadGrant;   // register the current winner
    logic dropGrant;   // clear the held grant
    logic markServed;  // lock out the requester whose grant completes
    logic newRound;    // clear all lockouts, a new round begins
    logic clearBars;   // fairness off: clear all lockouts
  } arbStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } arbState_t;

endpackage

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int NUM_REQ = 16,
  parameter int PRIO_W  = 4,
  parameter int IDX_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] reqVec,
  input  logic               fairEn,
  input  logic               prioWrEn,
  input  logic [IDX_W-1:0]   prioWrIdx,
  input  logic [PRIO_W-1:0]  prioWrData,
  input  arbStrobes_t        strobes,
  output logic [NUM_REQ-1:0] grantVec,
  output logic [IDX_W-1:0]   grantIdx,
  output logic               anyCand,
  output logic               freshEmpty
);

  logic [NUM_REQ-1:0][PRIO_W-1:0] prioReg;
  logic [NUM_REQ-1:0] barVec, barNext;
  logic [NUM_REQ-1:0] pendVec, candVec, winOneHot;
  logic [IDX_W-1:0]   winIdx;
  logic [PRIO_W-1:0]  winPrio;
  logic               winFound;

  // Priority registers: reset value is the requester index
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REQ; i++) begin
      if (rst)
        prioReg[i] <= PRIO_W'(i);
      else if (prioWrEn && (prioWrIdx == IDX_W'(i)))
        prioReg[i] <= prioWrData;
    end
  end

  // Candidate set: unlocked requesters, or all of them once none are left
  assign pendVec    = reqVec & ~barVec;
  assign freshEmpty = (pendVec == '0);
  assign candVec    = (!fairEn || freshEmpty) ? reqVec : pendVec;
  assign anyCand    = |candVec;

  // Winner: smallest priority value, the lower index wins a tie
  always_comb begin
    winIdx   = '0;
    winPrio  = '1;
    winFound = 1'b0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (candVec[i] && (!winFound || (prioReg[i] < winPrio))) begin
        winFound = 1'b1;
        winIdx   = IDX_W'(i);
        winPrio  = prioReg[i];
      end
    end
  end

  // Winner index to one-hot decode
  for (genvar g = 0; g < NUM_REQ; g++) begin : g_dec
    assign winOneHot[g] = (winIdx == IDX_W'(g));
  end

  // Lockout registers
  always_comb begin
    barNext = barVec;
    if (strobes.newRound)
      barNext = '0;
    if (strobes.markServed)
      barNext[grantIdx] = 1'b1;
    if (strobes.clearBars)
      barNext = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)
      barVec <= '0;
    else
      barVec <= barNext;
  end

  // Grant registers
  always_ff @(posedge clk) begin
    if (rst) begin
      grantVec <= '0;
      grantIdx <= '0;
    end else if (strobes.loadGrant) begin
      grantVec <= winOneHot;
      grantIdx <= winIdx;
    end else if (strobes.dropGrant) begin
      grantVec <= '0;
      grantIdx <= '0;
    end
  end

  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grantVec));

  // R3
  grant_idx_match_chk: assert property (@(posedge clk) disable iff (rst)
    (grantVec != '0) |-> grantVec[grantIdx]);

  // R4
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((grantVec != '0) && !strobes.dropGrant) |=> $stable(grantVec));

  // R2
  grant_requested_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.loadGrant |=> ((grantVec & $past(reqVec)) != '0));

  // R8
  served_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.markServed && !strobes.clearBars) |=> barVec[$past(grantIdx)]);

  // R13
  fair_off_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !fairEn |=> (barVec == '0));

endmodule

// File: rtl/arb_control.sv
module arb_control
  import arb_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        fairEn,
  input  logic        xferDone,
  input  logic        anyCand,
  input  logic        freshEmpty,
  output arbStrobes_t strobes,
  output logic        busy
);

  arbState_t state, stateNext;

  always_comb begin
    strobes           = '0;
    strobes.clearBars = !fairEn;
    stateNext         = state;
    case (state)
      ST_IDLE: begin
        strobes.newRound = fairEn && freshEmpty;
        if (anyCand) begin
          strobes.loadGrant = 1'b1;
          stateNext         = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (xferDone) begin
          strobes.dropGrant  = 1'b1;
          strobes.markServed = fairEn;
          stateNext          = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      state <= ST_IDLE;
    else
      state <= stateNext;
  end

  assign busy = (state == ST_HOLD);

  // R4
  hold_until_done_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !xferDone) |=> busy);

  // R5
  release_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && xferDone) |=> !busy);

  // R6
  idle_no_cand_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !anyCand) |=> !busy);

endmodule

// File: rtl/fair_prio_arbiter.sv
module fair_prio_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_REQ = 16,
  parameter int PRIO_W  = 4,
  parameter int IDX_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] reqVec,
  input  logic               fairEn,
  input  logic               xferDone,
  input  logic               prioWrEn,
  input  logic [IDX_W-1:0]   prioWrIdx,
  input  logic [PRIO_W-1:0]  prioWrData,
  output logic [NUM_REQ-1:0] grantVec,
  output logic [IDX_W-1:0]   grantIdx,
  output logic               busy
);

  arbStrobes_t strobes;
  logic        anyCand;
  logic        freshEmpty;

  arb_control ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .fairEn     (fairEn),
    .xferDone   (xferDone),
    .anyCand    (anyCand),
    .freshEmpty (freshEmpty),
    .strobes    (strobes),
    .busy       (busy)
  );

  arb_datapath #(
    .NUM_REQ (NUM_REQ),
    .PRIO_W  (PRIO_W),
    .IDX_W   (IDX_W)
  ) dp_i (
    .clk        (clk),
    .rst        (rst),
    .reqVec     (reqVec),
    .fairEn     (fairEn),
    .prioWrEn   (prioWrEn),
    .prioWrIdx  (prioWrIdx),
    .prioWrData (prioWrData),
    .strobes    (strobes),
    .grantVec   (grantVec),
    .grantIdx   (grantIdx),
    .anyCand    (anyCand),
    .freshEmpty (freshEmpty)
  );

  // R3
  busy_grant_agree_chk: assert property (@(posedge clk) disable iff (rst)
    busy == (grantVec != '0));

endmodule

// File: tb/fair_prio_arbiter_tb_top.sv
`timescale 1ns/1ps
module fair_prio_arbiter_tb_top;

  localparam int NR = 16;
  localparam int PW = 4;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NR-1:0] reqVec = '0;
  logic          fairEn = 1'b0;
  logic          xferDone = 1'b0;
  logic          prioWrEn = 1'b0;
  logic [IW-1:0] prioWrIdx = '0;
  logic [PW-1:0] prioWrData = '0;
  logic [NR-1:0] grantVec;
  logic [IW-1:0] grantIdx;
  logic          busy;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fair_prio_arbiter #(.NUM_REQ(NR), .PRIO_W(PW), .IDX_W(IW)) dut_i (
    .clk(clk), .rst(rst), .reqVec(reqVec), .fairEn(fairEn),
    .xferDone(xferDone), .prioWrEn(prioWrEn), .prioWrIdx(prioWrIdx),
    .prioWrData(prioWrData), .grantVec(grantVec), .grantIdx(grantIdx),
    .busy(busy)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expectGrant(input string tag, input int idx);
    check({tag, " busy"}, 32'(busy), 32'd1);
    check({tag, " idx"}, 32'(grantIdx), 32'(idx));
    check({tag, " vec"}, 32'(grantVec), 32'(1) << idx);
  endtask

  task automatic expectIdle(input string tag);
    check({tag, " busy"}, 32'(busy), 32'd0);
    check({tag, " vec"}, 32'(grantVec), 32'd0);
  endtask

  task automatic doReset();
    rst = 1'b1; reqVec = '0; fairEn = 1'b0; xferDone = 1'b0; prioWrEn = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Pulse done, check the idle gap (R5), land on the next decision
  task automatic completeXfer(input string tag);
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
    expectIdle({tag, " R5 gap"});
    @(negedge clk);
  endtask

  task automatic setPrio(input int idx, input int val);
    prioWrEn = 1'b1; prioWrIdx = IW'(idx); prioWrData = PW'(val);
    @(negedge clk);
    prioWrEn = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    expectIdle("R1 reset state");
    check("R1 reset idx", 32'(grantIdx), 32'd0);
    @(negedge clk);
    expectIdle("R6 no request");
    reqVec = '1;
    @(negedge clk);
    expectGrant("R1 all req", 0);
    reqVec = 16'h8010;
    completeXfer("R1");
    expectGrant("R1 reset prio", 4);
    reqVec = 16'h8000;
    completeXfer("R1 top");
    expectGrant("R1 top index", 15);
  endtask

  task automatic testPrioWrite();
    doReset();
    setPrio(12, 0);
    reqVec = 16'h1008;
    @(negedge clk);
    expectGrant("R11 written prio", 12);
    setPrio(7, 0);
    reqVec = 16'h1080;
    completeXfer("R11");
    expectGrant("R2 tie lower idx", 7);
    reqVec = 16'h1081;
    completeXfer("R2");
    expectGrant("R2 tie idx0", 0);
  endtask

  task automatic testHold();
    doReset();
    reqVec = 16'h0020;
    @(negedge clk);
    expectGrant("R3 grant5", 5);
    reqVec = 16'h0002;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      expectGrant("R4 held", 5);
    end
    completeXfer("R4");
    expectGrant("R5 next decision", 1);
  endtask

  task automatic testNoFair();
    doReset();
    reqVec = 16'h0044;
    @(negedge clk);
    expectGrant("R7 first", 2);
    completeXfer("R7");
    expectGrant("R7 again", 2);
  endtask

  task automatic testFairRound();
    doReset();
    fairEn = 1'b1;
    reqVec = 16'h0244;
    @(negedge clk);
    expectGrant("R8 first", 2);
    completeXfer("R8");
    expectGrant("R8 second", 6);
    completeXfer("R8");
    expectGrant("R8 third", 9);
    completeXfer("R9");
    expectGrant("R9 new round", 2);
  endtask

  task automatic testDropBarred();
    doReset();
    fairEn = 1'b1;
    reqVec = 16'h0108;
    @(negedge clk);
    expectGrant("R10 first", 3);
    reqVec = 16'h0100;
    completeXfer("R10");
    expectGrant("R10 other", 8);
    completeXfer("R10");
    expectGrant("R10 not held open", 8);
  endtask

  task automatic testIdleDone();
    doReset();
    xferDone = 1'b1;
    repeat (2) @(negedge clk);
    expectIdle("R12 idle done");
    reqVec = 16'h0020;
    @(negedge clk);
    xferDone = 1'b0;
    expectGrant("R12 grant kept", 5);
    @(negedge clk);
    expectGrant("R12 still held", 5);
  endtask

  task automatic testFairOff();
    doReset();
    fairEn = 1'b1;
    reqVec = 16'h0244;
    @(negedge clk);
    expectGrant("R13 first", 2);
    completeXfer("R13");
    expectGrant("R13 second", 6);
    fairEn = 1'b0;
    @(negedge clk);
    fairEn = 1'b1;
    expectGrant("R13 hold", 6);
    completeXfer("R13");
    expectGrant("R13 cleared", 2);
  endtask

  initial begin
    testReset();
    testPrioWrite();
    testHold();
    testNoFair();
    testFairRound();
    testDropBarred();
    testIdleDone();
    testFairOff();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule